// File: doc/BRIEF.md
# Cascaded Trigger Matrix

This block turns 24 discriminator lines into trigger decisions through three registered layers. The first layer holds eight counting units. Each unit picks a subset of the raw lines through a mask and fires when enough of the picked lines are high. The second layer holds eight OR units. Each OR unit combines a masked choice of raw lines and counting-unit outputs. The third layer holds two AND units. Each AND unit demands that every masked raw line and every masked OR output be high.

A front-panel selector routes one signal from the matrix to a single output. The selector delays every source it can pick so that they all reach that output with the same delay. All settings live in 32-bit words that are written and read over a plain address/data register bus. Read data is combinational.

The raw lines are numbered 0 to 23. Lines 2p and 2p+1 carry the two channels of connector p, and the connectors are taken in front-panel order. Reset is asserted asynchronously. Its release passes through a two-flop synchronizer.

Top module: `trig_matrix`

## Requirements
- R1: While reset is held, and after its release, every trigger output is low and every configuration word reads back as zero until it is written.
- R2: A write with `cfg_we` high stores `cfg_wdata` on the next clock. The word is then read back unchanged on `cfg_rdata` at the same address. Addresses: counting units A..H at 0x60..0x67, OR units A..H at 0x68..0x6F, AND units A and B at 0x70 and 0x71, selector at 0x50.
- R3: Reading any other address returns zero. Writing any other address changes no stored word.
- R4: Counting unit g uses bits [23:0] of its word as the line mask, where bit n selects line n, and bits [31:24] as the threshold. `mult_trig[g]` is high one clock after the number of selected high lines is greater than or equal to a non-zero threshold.
- R5: A counting unit whose threshold is zero keeps its output low, whatever its mask and the lines.
- R6: OR unit j uses bits [23:0] to select raw lines and bit 24+g to select counting unit g. `or_trig[j]` is the OR of the selected signals and lags the raw lines by two clocks. An all-zero mask gives low.
- R7: AND unit k uses bits [23:0] to select raw lines and bit 24+j to select OR unit j. `and_trig[k]` is the AND of only the selected signals and lags the raw lines by three clocks. An all-zero mask gives low.
- R8: `fp_trig` lags the raw lines by four clocks for every selector value. The selector value picks the source: 0..23 is raw line n, 24/25 is counting unit A/B, 26/27 is OR unit A/B, and 28/29 is AND unit A/B. Any other value gives low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disc_in | input | 24 | Discriminator lines, bit n is line n |
| cfg_addr | input | 8 | Register address |
| cfg_we | input | 1 | Write strobe |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, zero when unmapped |
| mult_trig | output | 8 | Counting-unit outputs A..H |
| or_trig | output | 8 | OR-unit outputs A..H |
| and_trig | output | 2 | AND-unit outputs A, B |
| fp_trig | output | 1 | Selected front-panel trigger |

## Verification
The bench builds the block with its default parameters: 24 lines, eight counting and eight OR units, two AND units and two selectable units per layer. With these values the whole selector code space is reachable, from raw lines through AND outputs and on into values past 29. So are thresholds equal to the selected-line count, a full 24-line threshold, and a zero threshold. Patterns change every clock, so that a wrong delay in any layer or in the selector shows up as a mismatch.

// File: rtl/trig_matrix_pkg.sv
package trig_matrix_pkg;
  localparam int TM_DATA_W    = 32;
  localparam int TM_N_IN      = 24;
  localparam int TM_N_GRP     = 8;
  localparam int TM_N_AND     = 2;
  localparam int TM_ADDR_W    = 8;
  localparam int TM_FP_PER    = 2;
  localparam int TM_ADR_FPSEL = 'h50;
  localparam int TM_ADR_MULT  = 'h60;
  localparam int TM_ADR_OR    = 'h68;
  localparam int TM_ADR_AND   = 'h70;

  function automatic int tm_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tm_regfile.sv
module tm_regfile
  import trig_matrix_pkg::*;
#(
  parameter int NG = TM_N_GRP,
  parameter int NA = TM_N_AND,
  parameter int AW = TM_ADDR_W,
  parameter int DW = TM_DATA_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          cfg_addr,
  input  logic                   cfg_we,
  input  logic [DW-1:0]          cfg_wdata,
  output logic [DW-1:0]          cfg_rdata,
  output logic [NG-1:0][DW-1:0]  mult_cfg,
  output logic [NG-1:0][DW-1:0]  or_cfg,
  output logic [NA-1:0][DW-1:0]  and_cfg,
  output logic [DW-1:0]          fp_sel
);

  for (genvar g = 0; g < NG; g++) begin : g_mult
    logic          en;
    logic [DW-1:0] q;
    assign en = cfg_we && (cfg_addr == AW'(TM_ADR_MULT + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= cfg_wdata;
    end
    assign mult_cfg[g] = q;
  end

  for (genvar g = 0; g < NG; g++) begin : g_or
    logic          en;
    logic [DW-1:0] q;
    assign en = cfg_we && (cfg_addr == AW'(TM_ADR_OR + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= cfg_wdata;
    end
    assign or_cfg[g] = q;
  end

  for (genvar k = 0; k < NA; k++) begin : g_and
    logic          en;
    logic [DW-1:0] q;
    assign en = cfg_we && (cfg_addr == AW'(TM_ADR_AND + k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= cfg_wdata;
    end
    assign and_cfg[k] = q;
  end

  logic fp_en;
  logic [DW-1:0] fp_q;
  assign fp_en = cfg_we && (cfg_addr == AW'(TM_ADR_FPSEL));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fp_q <= '0;
    else if (fp_en) fp_q <= cfg_wdata;
  end
  assign fp_sel = fp_q;

  // Read path: unmapped addresses fall through to zero.
  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == AW'(TM_ADR_FPSEL)) cfg_rdata = fp_q;
    for (int g = 0; g < NG; g++) begin
      if (cfg_addr == AW'(TM_ADR_MULT + g)) cfg_rdata = mult_cfg[g];
      if (cfg_addr == AW'(TM_ADR_OR + g))   cfg_rdata = or_cfg[g];
    end
    for (int k = 0; k < NA; k++) begin
      if (cfg_addr == AW'(TM_ADR_AND + k))  cfg_rdata = and_cfg[k];
    end
  end

endmodule

// File: rtl/tm_mult_unit.sv
module tm_mult_unit
  import trig_matrix_pkg::*;
#(
  parameter int NI = TM_N_IN,
  parameter int DW = TM_DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NI-1:0] src,
  input  logic [DW-1:0] cfg,
  output logic          hit
);

  localparam int THR_W = DW - NI;
  localparam int CNT_W = $clog2(NI + 1);
  localparam int CMP_W = tm_max(CNT_W, THR_W);

  logic [NI-1:0]    mask;
  logic [THR_W-1:0] thr;
  logic [CNT_W-1:0] cnt;
  logic             hit_d;

  assign mask = cfg[NI-1:0];
  assign thr  = cfg[DW-1:NI];

  // Population count of the selected active lines.
  always_comb begin
    cnt = '0;
    for (int i = 0; i < NI; i++) begin
      cnt = cnt + CNT_W'(src[i] & mask[i]);
    end
  end

  always_comb begin
    hit_d = (thr != '0) && (CMP_W'(cnt) >= CMP_W'(thr));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit <= 1'b0;
    else        hit <= hit_d;
  end

endmodule

// File: rtl/tm_gate_unit.sv
module tm_gate_unit #(
  parameter int SW     = 32,
  parameter bit IS_AND = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] src,
  input  logic [SW-1:0] mask,
  output logic          q
);

  logic d;

  if (IS_AND) begin : g_and
    // Unselected bits are forced high; an empty mask never fires.
    assign d = (|mask) & (&(src | ~mask));
  end else begin : g_or
    assign d = |(src & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end

endmodule

// File: rtl/tm_fp_select.sv
module tm_fp_select
  import trig_matrix_pkg::*;
#(
  parameter int NI  = TM_N_IN,
  parameter int FPN = TM_FP_PER,
  parameter int DW  = TM_DATA_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  code,
  input  logic [NI-1:0]  raw,
  input  logic [FPN-1:0] mult,
  input  logic [FPN-1:0] orv,
  input  logic [FPN-1:0] andv,
  output logic           q
);

  logic d;

  always_comb begin
    d = 1'b0;
    for (int i = 0; i < NI; i++) begin
      if (code == DW'(i)) d = raw[i];
    end
    for (int i = 0; i < FPN; i++) begin
      if (code == DW'(NI + i))           d = mult[i];
      if (code == DW'(NI + FPN + i))     d = orv[i];
      if (code == DW'(NI + 2 * FPN + i)) d = andv[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end

endmodule

// File: rtl/trig_matrix.sv
module trig_matrix
  import trig_matrix_pkg::*;
#(
  parameter int NI  = TM_N_IN,
  parameter int NG  = TM_N_GRP,
  parameter int NA  = TM_N_AND,
  parameter int AW  = TM_ADDR_W,
  parameter int DW  = TM_DATA_W,
  parameter int FPN = TM_FP_PER
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NI-1:0] disc_in,
  input  logic [AW-1:0] cfg_addr,
  input  logic          cfg_we,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic [NG-1:0] mult_trig,
  output logic [NG-1:0] or_trig,
  output logic [NA-1:0] and_trig,
  output logic          fp_trig
);

  localparam int SW = NI + NG;

  // Reset: asynchronous assertion, release through two flops.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NG-1:0][DW-1:0] mult_cfg;
  logic [NG-1:0][DW-1:0] or_cfg;
  logic [NA-1:0][DW-1:0] and_cfg;
  logic [DW-1:0]         fp_sel;

  tm_regfile #(.NG(NG), .NA(NA), .AW(AW), .DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cfg_addr (cfg_addr),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .mult_cfg (mult_cfg),
    .or_cfg   (or_cfg),
    .and_cfg  (and_cfg),
    .fp_sel   (fp_sel)
  );

  // Raw-line delay line keeps each layer aligned with its own inputs.
  logic [2:0][NI-1:0] raw_q, raw_d;
  always_comb raw_d = {raw_q[1], raw_q[0], disc_in};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  logic [NG-1:0] mult_q;
  logic [NG-1:0] or_q;
  logic [NA-1:0] and_q;

  for (genvar g = 0; g < NG; g++) begin : g_mult
    tm_mult_unit #(.NI(NI), .DW(DW)) u_mult (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .src  (disc_in),
      .cfg  (mult_cfg[g]),
      .hit  (mult_q[g])
    );
  end

  for (genvar j = 0; j < NG; j++) begin : g_or
    tm_gate_unit #(.SW(SW), .IS_AND(1'b0)) u_or (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .src  ({mult_q, raw_q[0]}),
      .mask (or_cfg[j][SW-1:0]),
      .q    (or_q[j])
    );
  end

  for (genvar k = 0; k < NA; k++) begin : g_and
    tm_gate_unit #(.SW(SW), .IS_AND(1'b1)) u_and (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .src  ({or_q, raw_q[1]}),
      .mask (and_cfg[k][SW-1:0]),
      .q    (and_q[k])
    );
  end

  // Align the selectable layer outputs to the AND-layer stage.
  logic [1:0][FPN-1:0] m_al_q, m_al_d;
  logic [FPN-1:0]      o_al_q, o_al_d;
  always_comb begin
    m_al_d = {m_al_q[0], mult_q[FPN-1:0]};
    o_al_d = or_q[FPN-1:0];
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_al_q <= '0;
      o_al_q <= '0;
    end else begin
      m_al_q <= m_al_d;
      o_al_q <= o_al_d;
    end
  end

  tm_fp_select #(.NI(NI), .FPN(FPN), .DW(DW)) u_fp (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .code (fp_sel),
    .raw  (raw_q[2]),
    .mult (m_al_q[1]),
    .orv  (o_al_q),
    .andv (and_q[FPN-1:0]),
    .q    (fp_trig)
  );

  assign mult_trig = mult_q;
  assign or_trig   = or_q;
  assign and_trig  = and_q;

endmodule

// File: rtl/trig_matrix_chk.sv
module trig_matrix_chk
  import trig_matrix_pkg::*;
#(
  parameter int NI = TM_N_IN,
  parameter int NG = TM_N_GRP,
  parameter int NA = TM_N_AND,
  parameter int AW = TM_ADDR_W,
  parameter int DW = TM_DATA_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NI-1:0] disc_in,
  input logic [AW-1:0] cfg_addr,
  input logic          cfg_we,
  input logic [DW-1:0] cfg_wdata,
  input logic [DW-1:0] cfg_rdata,
  input logic [NG-1:0] mult_trig,
  input logic [NG-1:0] or_trig,
  input logic [NA-1:0] and_trig,
  input logic          fp_trig
);

  localparam int SW = NI + NG;

  // Shadow copy of the configuration, rebuilt from bus writes.
  logic [NG-1:0][DW-1:0] sh_mult;
  logic [NG-1:0][DW-1:0] sh_or;
  logic [NA-1:0][DW-1:0] sh_and;
  logic [DW-1:0]         sh_fp;
  logic                  mapped;

  for (genvar g = 0; g < NG; g++) begin : g_shm
    logic [DW-1:0] qm, qo;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        qm <= '0;
        qo <= '0;
      end else begin
        if (cfg_we && cfg_addr == AW'(TM_ADR_MULT + g)) qm <= cfg_wdata;
        if (cfg_we && cfg_addr == AW'(TM_ADR_OR + g))   qo <= cfg_wdata;
      end
    end
    assign sh_mult[g] = qm;
    assign sh_or[g]   = qo;
  end

  for (genvar k = 0; k < NA; k++) begin : g_sha
    logic [DW-1:0] qa;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) qa <= '0;
      else if (cfg_we && cfg_addr == AW'(TM_ADR_AND + k)) qa <= cfg_wdata;
    end
    assign sh_and[k] = qa;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_fp <= '0;
    else if (cfg_we && cfg_addr == AW'(TM_ADR_FPSEL)) sh_fp <= cfg_wdata;
  end

  always_comb begin
    mapped = (cfg_addr == AW'(TM_ADR_FPSEL))
          || (cfg_addr >= AW'(TM_ADR_MULT) && cfg_addr < AW'(TM_ADR_MULT + NG))
          || (cfg_addr >= AW'(TM_ADR_OR)   && cfg_addr < AW'(TM_ADR_OR + NG))
          || (cfg_addr >= AW'(TM_ADR_AND)  && cfg_addr < AW'(TM_ADR_AND + NA));
  end

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (cfg_rdata == '0)); // R3

  AST_FPSEL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == AW'(TM_ADR_FPSEL)) |-> (cfg_rdata == sh_fp)); // R2

  AST_FP_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fp_trig |-> ($past(sh_fp) < DW'(NI + 6))); // R8

  for (genvar g = 0; g < NG; g++) begin : g_am
    AST_MULT_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr == AW'(TM_ADR_MULT + g)) |-> (cfg_rdata == sh_mult[g])); // R2

    AST_MULT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      mult_trig[g] |-> ($countones($past(disc_in) & $past(sh_mult[g][NI-1:0]))
                        >= int'($past(sh_mult[g][DW-1:NI])))); // R4

    AST_MULT_ZERO_THR: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sh_mult[g][DW-1:NI]) == '0) |-> !mult_trig[g]); // R5

    AST_OR_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      or_trig[g] |-> ($past(sh_or[g]) != '0)); // R6
  end

  for (genvar k = 0; k < NA; k++) begin : g_aa
    AST_AND_ALL_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      and_trig[k] |-> (($past(sh_and[k]) != '0) &&
        ((({$past(or_trig), $past(disc_in, 3)} & $past(sh_and[k][SW-1:0]))
          == $past(sh_and[k][SW-1:0]))))); // R7
  end

endmodule

bind trig_matrix trig_matrix_chk #(
  .NI(NI), .NG(NG), .NA(NA), .AW(AW), .DW(DW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .disc_in  (disc_in),
  .cfg_addr (cfg_addr),
  .cfg_we   (cfg_we),
  .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata),
  .mult_trig(mult_trig),
  .or_trig  (or_trig),
  .and_trig (and_trig),
  .fp_trig  (fp_trig)
);

// File: tb/trig_matrix_bench.sv
module trig_matrix_bench;
  import trig_matrix_pkg::*;

  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic [23:0] disc_in;
  logic [7:0]  cfg_addr;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [7:0]  mult_trig;
  logic [7:0]  or_trig;
  logic [1:0]  and_trig;
  logic        fp_trig;

  trig_matrix u_trig_matrix (
    .clk(clk), .rst_n(rst_n), .disc_in(disc_in),
    .cfg_addr(cfg_addr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .mult_trig(mult_trig), .or_trig(or_trig),
    .and_trig(and_trig), .fp_trig(fp_trig)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // Bench-side configuration model.
  logic [31:0] b_mult [8];
  logic [31:0] b_or   [8];
  logic [31:0] b_and  [2];
  logic [31:0] b_fp;

  typedef struct {
    int         due;
    int         kind;
    logic [7:0] exp;
  } item_t;
  item_t sb[$];

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic bit is_mapped(input logic [7:0] a);
    return (a == 8'h50) || (a >= 8'h60 && a <= 8'h71);
  endfunction

  function automatic logic [7:0] m_mult(input logic [23:0] x);
    logic [7:0] r;
    for (int g = 0; g < 8; g++) begin
      r[g] = (b_mult[g][31:24] != 0) &&
             ($countones(x & b_mult[g][23:0]) >= int'(b_mult[g][31:24]));
    end
    return r;
  endfunction

  function automatic logic [7:0] m_or(input logic [23:0] x, input logic [7:0] m);
    logic [7:0] r;
    for (int j = 0; j < 8; j++) r[j] = |({m, x} & b_or[j]);
    return r;
  endfunction

  function automatic logic [1:0] m_and(input logic [23:0] x, input logic [7:0] o);
    logic [1:0] r;
    for (int k = 0; k < 2; k++)
      r[k] = (b_and[k] != 0) && (({o, x} & b_and[k]) == b_and[k]);
    return r;
  endfunction

  function automatic logic m_fp(input logic [23:0] x, input logic [7:0] m,
                                input logic [7:0] o, input logic [1:0] a);
    if (b_fp < 24) return x[b_fp[4:0]];
    if (b_fp < 26) return m[b_fp - 24];
    if (b_fp < 28) return o[b_fp - 26];
    if (b_fp < 30) return a[b_fp - 28];
    return 1'b0;
  endfunction

  function automatic string req_of(input int kind);
    case (kind)
      0: return "R4";
      1: return "R6";
      2: return "R7";
      3: return "R8";
      default: return "R5";
    endcase
  endfunction

  // Monitor: compare scoreboard items whose cycle has come.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].due <= cyc) begin
          logic [7:0] act;
          case (sb[i].kind)
            0: act = mult_trig;
            1: act = or_trig;
            2: act = {6'b0, and_trig};
            3: act = {7'b0, fp_trig};
            default: act = {7'b0, mult_trig[2]};
          endcase
          if (sb[i].due < cyc) chk(1'b0, req_of(sb[i].kind), 32'hdead, {24'b0, sb[i].exp});
          else chk(act == sb[i].exp, req_of(sb[i].kind), {24'b0, act}, {24'b0, sb[i].exp});
          sb.delete(i);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk);
    #1;
    cfg_addr  = a;
    cfg_wdata = d;
    cfg_we    = 1'b1;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    if (a == 8'h50) b_fp = d;
    else if (a >= 8'h60 && a <= 8'h67) b_mult[a - 8'h60] = d;
    else if (a >= 8'h68 && a <= 8'h6F) b_or[a - 8'h68] = d;
    else if (a == 8'h70 || a == 8'h71) b_and[a - 8'h70] = d;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(posedge clk);
    #2;
    cfg_addr = a;
    #1;
    chk(cfg_rdata === exp, req, cfg_rdata, exp);
  endtask

  // Driver: apply one pattern and queue what each output must show.
  task automatic apply(input logic [23:0] x);
    logic [7:0] m, o;
    logic [1:0] a;
    logic       f;
    @(posedge clk);
    #1;
    disc_in = x;
    m = m_mult(x);
    o = m_or(x, m);
    a = m_and(x, o);
    f = m_fp(x, m, o, a);
    sb.push_back('{cyc + 1, 0, m});
    sb.push_back('{cyc + 1, 4, {7'b0, m[2]}});
    sb.push_back('{cyc + 2, 1, o});
    sb.push_back('{cyc + 3, 2, {6'b0, a}});
    sb.push_back('{cyc + 4, 3, {7'b0, f}});
  endtask

  task automatic flush();
    repeat (6) @(posedge clk);
  endtask

  function automatic logic [23:0] lfsr(input logic [23:0] x);
    return {x[22:0], x[23] ^ x[22] ^ x[21] ^ x[16]};
  endfunction

  task automatic run_pats(input int n_rand);
    logic [23:0] fixed [12] = '{24'h000000, 24'h000001, 24'h000003, 24'h00000F,
                                24'hFFFFFF, 24'h000020, 24'h001400, 24'h001403,
                                24'h100000, 24'h000007, 24'h800006, 24'h000000};
    logic [23:0] x = 24'h5A3C91;
    for (int i = 0; i < 12; i++) apply(fixed[i]);
    for (int i = 0; i < n_rand; i++) begin
      x = lfsr(x);
      apply(x);
    end
    flush();
  endtask

  task automatic clear_all();
    wr(8'h50, 32'h0);
    for (int i = 0; i < 8; i++) begin
      wr(8'(8'h60 + i), 32'h0);
      wr(8'(8'h68 + i), 32'h0);
    end
    wr(8'h70, 32'h0);
    wr(8'h71, 32'h0);
  endtask

  initial begin
    rst_n     = 1'b0;
    disc_in   = '0;
    cfg_addr  = '0;
    cfg_we    = 1'b0;
    cfg_wdata = '0;
    b_fp      = '0;
    for (int i = 0; i < 8; i++) begin
      b_mult[i] = '0;
      b_or[i]   = '0;
    end
    b_and[0] = '0;
    b_and[1] = '0;

    // R1: outputs quiet while reset is held.
    repeat (3) @(posedge clk);
    #2;
    chk(mult_trig == 0, "R1", {24'b0, mult_trig}, 0);
    chk(or_trig == 0,   "R1", {24'b0, or_trig}, 0);
    chk(and_trig == 0,  "R1", {30'b0, and_trig}, 0);
    chk(fp_trig == 0,   "R1", {31'b0, fp_trig}, 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: every word reads zero after reset.
    rd_chk(8'h50, 32'h0, "R1");
    for (int a = 8'h60; a <= 8'h71; a++) rd_chk(8'(a), 32'h0, "R1");

    // R2: write distinct values and read them back.
    wr(8'h50, 32'hC0DE0050);
    for (int a = 8'h60; a <= 8'h71; a++) wr(8'(a), 32'h13572468 ^ (32'(a) * 32'h01010101));
    rd_chk(8'h50, 32'hC0DE0050, "R2");
    for (int a = 8'h60; a <= 8'h71; a++) rd_chk(8'(a), 32'h13572468 ^ (32'(a) * 32'h01010101), "R2");

    // R3: unmapped addresses read zero and do not disturb stored words.
    wr(8'h5F, 32'hFFFFFFFF);
    wr(8'h72, 32'hFFFFFFFF);
    wr(8'h4F, 32'hFFFFFFFF);
    wr(8'h00, 32'hFFFFFFFF);
    wr(8'hFF, 32'hFFFFFFFF);
    rd_chk(8'h5F, 32'h0, "R3");
    rd_chk(8'h72, 32'h0, "R3");
    rd_chk(8'h51, 32'h0, "R3");
    rd_chk(8'hFF, 32'h0, "R3");
    for (int a = 8'h60; a <= 8'h71; a++) rd_chk(8'(a), 32'h13572468 ^ (32'(a) * 32'h01010101), "R3");
    rd_chk(8'h50, 32'hC0DE0050, "R3");
    if (!is_mapped(8'h5F)) rd_chk(8'h5F, 32'h0, "R3");

    // Phase A: threshold, zero-threshold, empty-mask cases (R4 R5 R6 R7).
    clear_all();
    wr(8'h60, 32'h0200000F);  // A: lines 0..3, needs 2
    wr(8'h61, 32'h18FFFFFF);  // B: all 24 lines
    wr(8'h62, 32'h00FFFFFF);  // C: zero threshold
    wr(8'h63, 32'h01F00000);  // D: lines 20..23, needs 1
    wr(8'h64, 32'h03000007);  // E: lines 0..2, needs 3
    wr(8'h68, 32'h01000020);  // OR A: line 5 | mult A
    wr(8'h69, 32'h0A000000);  // OR B: mult B | mult D
    wr(8'h6A, 32'h00000400);  // OR C: line 10
    wr(8'h6B, 32'h10000000);  // OR D: mult E
    wr(8'h70, 32'h05001000);  // AND A: OR A & OR C & line 12
    flush();
    run_pats(40);

    // Phase B: AND B now in use, AND A over OR outputs only.
    wr(8'h71, 32'h02000003);
    wr(8'h70, 32'h0F000000);
    wr(8'h6B, 32'h10800000);
    flush();
    run_pats(40);

    // R8: sweep the selector, including values past the defined range.
    for (int c = 0; c < 34; c++) begin
      wr(8'h50, 32'(c));
      flush();
      run_pats(6);
    end

    flush();
    chk(sb.size() == 0, "R8", 32'(sb.size()), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule